// File: doc/BRIEF.md
# Debug Port Key-Unlock Gate

This block sits next to a test access port and decides whether debug/emulation access and booting from outside the chip are allowed. When the security strap is set, both stay closed after reset. The chip then runs only from its internal memory. A 64-bit key is moved into a dedicated serial data register one bit per shift strobe. An update strobe compares that register with the stored per-device key.

A compare passes only if exactly 64 shifts came before the update and every bit matches. A passing compare opens the gate, and the gate stays open until the next reset. A failing compare changes nothing and produces no indication. Each update clears the data register and its bit counter, so a scanned key cannot be shifted back out afterwards. With the security strap clear, the gate is open from reset.

Top module: `dbg_key_gate`

## Requirements
- R1: While `rst_n` is low and `sec_en` is 1, and in the first cycle after reset, `unlocked` is 0 and `shift_dout` is 0.
- R2: While `sec_en` is 0, `unlocked`, `emu_allow` and `ext_boot_allow` are 1 and `boot_int_only` is 0, from reset on and with no key scanned.
- R3: On each cycle with `shift_en` high, `shift_din` enters the register's top bit (bit KEY_W-1) and the register moves one place toward bit 0. The key is therefore sent least significant bit first. `shift_dout` shows bit 0, so after 64 shifts it shows the first bit that was sent.
- R4: An `update_en` cycle that follows exactly 64 shifts, with the shifted value equal to `dev_key`, sets `unlocked` to 1 from the next cycle on. It also raises `emu_allow` and `ext_boot_allow` and drops `boot_int_only`.
- R5: An update whose shifted value differs from `dev_key` in any bit leaves `unlocked` at 0. No other output reports the failure.
- R6: An update after any shift count other than 64 (for example 63 or 65) is a mismatch, even when the register holds `dev_key`. The shift count saturates at 65.
- R7: Once open, the gate stays open until reset. Later wrong or short keys do not close it.
- R8: Every update clears the data register and the shift count from the next cycle on. `shift_dout` reads 0 afterwards, and the next key is counted from zero.
- R9: When `shift_en` and `update_en` are high in the same cycle, the update takes priority. The compare uses the register as it was before that cycle, and the shift bit is discarded.
- R10: While `sec_en` is 1 and the gate is closed, `emu_allow` and `ext_boot_allow` are 0 and `boot_int_only` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_en | input | 1 | Security strap: 1 locks the gate at reset |
| shift_en | input | 1 | Shift strobe for the key data register |
| shift_din | input | 1 | Serial key bit, least significant bit first |
| update_en | input | 1 | Update strobe: compare and clear |
| dev_key | input | KEY_W | Stored per-device key |
| shift_dout | output | 1 | Bit 0 of the key data register |
| unlocked | output | 1 | Gate open |
| emu_allow | output | 1 | Emulation/debug access enabled |
| ext_boot_allow | output | 1 | External boot sources enabled |
| boot_int_only | output | 1 | Execute only from internal memory |

## Verification
Suppose the shift count drifts, say from a missed saturation or a count that is not cleared. The result is either an unlock after a 63- or 65-bit scan, or a correct 64-bit key that fails to unlock. In both cases the error shows on `unlocked` in the cycle after the offending update. A data register that is not cleared shows up at once as a nonzero `shift_dout` in the cycle after an update. A lock state that loses its stickiness shows as `unlocked` falling one cycle after a later wrong-key update. Reversed bit order only shows after a full 64-bit scan. At that point `shift_dout` shows the wrong bit and the correct key is refused.

// File: rtl/dbg_key_pkg.sv
package dbg_key_pkg;

  typedef enum logic {
    LK_SEALED = 1'b0,
    LK_OPEN   = 1'b1
  } lock_state_t;

  // Gate-open decision: a cleared strap opens the gate regardless of state.
  function automatic logic gate_open(input logic strap, input lock_state_t st);
    return (!strap) || (st == LK_OPEN);
  endfunction

endpackage

// File: rtl/dkg_key_sreg.sv
module dkg_key_sreg #(
  parameter int KEY_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             clear,
  input  logic             din,
  output logic [KEY_W-1:0] value,
  output logic             dout
);

  logic [KEY_W-1:0] sreg_q;

  // Clear wins over shift; new bits enter at the top so the first bit lands at 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (clear) begin
      sreg_q <= '0;
    end else if (shift_en) begin
      sreg_q <= {din, sreg_q[KEY_W-1:1]};
    end
  end

  assign value = sreg_q;
  assign dout  = sreg_q[0];

endmodule

// File: rtl/dkg_len_cnt.sv
module dkg_len_cnt #(
  parameter int KEY_W = 64,
  parameter int CNT_W = $clog2(KEY_W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             len_exact
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(KEY_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(KEY_W + 1);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return (c == CNT_OVER) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      cnt_q <= next_count(cnt_q);
    end
  end

  assign count     = cnt_q;
  assign len_exact = (cnt_q == CNT_FULL);

endmodule

// File: rtl/dkg_lock_ctl.sv
module dkg_lock_ctl
  import dbg_key_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_en,
  input  logic        set_open,
  output lock_state_t state,
  output logic        open
);

  lock_state_t st_q;

  // Sticky: once open, only reset returns the state to sealed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LK_SEALED;
    end else if (set_open) begin
      st_q <= LK_OPEN;
    end
  end

  assign state = st_q;
  assign open  = gate_open(sec_en, st_q);

endmodule

// File: rtl/dbg_key_gate.sv
module dbg_key_gate
  import dbg_key_pkg::*;
#(
  parameter int KEY_W = 64,
  localparam int CNT_W = $clog2(KEY_W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_en,
  input  logic             shift_en,
  input  logic             shift_din,
  input  logic             update_en,
  input  logic [KEY_W-1:0] dev_key,
  output logic             shift_dout,
  output logic             unlocked,
  output logic             emu_allow,
  output logic             ext_boot_allow,
  output logic             boot_int_only
);

  logic [KEY_W-1:0] key_sh;
  logic [CNT_W-1:0] len_cnt;
  logic             len_ok;
  logic             key_eq;
  logic             shift_go;
  logic             set_unlock;
  lock_state_t      lk_state;

  // Update has priority over a coincident shift.
  assign shift_go   = shift_en && !update_en;
  assign key_eq     = (key_sh == dev_key);
  assign set_unlock = update_en && len_ok && key_eq;

  dkg_key_sreg #(.KEY_W(KEY_W)) u_sreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_go),
    .clear    (update_en),
    .din      (shift_din),
    .value    (key_sh),
    .dout     (shift_dout)
  );

  dkg_len_cnt #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_go),
    .clear     (update_en),
    .count     (len_cnt),
    .len_exact (len_ok)
  );

  dkg_lock_ctl u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_en   (sec_en),
    .set_open (set_unlock),
    .state    (lk_state),
    .open     (unlocked)
  );

  assign emu_allow      = unlocked;
  assign ext_boot_allow = unlocked;
  assign boot_int_only  = !unlocked;

endmodule

// File: rtl/dbg_key_gate_chk.sv
module dbg_key_gate_chk
  import dbg_key_pkg::*;
#(
  parameter int KEY_W = 64,
  parameter int CNT_W = $clog2(KEY_W + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_en,
  input logic             update_en,
  input logic             shift_dout,
  input logic             unlocked,
  input logic [CNT_W-1:0] len_cnt,
  input logic             set_unlock,
  input lock_state_t      lk_state
);

  p_open_needs_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_en && $past(sec_en) && $rose(unlocked)) |-> $past(update_en));

  p_len_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_unlock |-> (len_cnt == CNT_W'(KEY_W)));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    len_cnt <= CNT_W'(KEY_W + 1));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_state == LK_OPEN) |=> (lk_state == LK_OPEN));

  p_clear_after_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> (!shift_dout && len_cnt == '0));

  p_strap_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_en |-> unlocked);

endmodule

bind dbg_key_gate dbg_key_gate_chk #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_en     (sec_en),
  .update_en  (update_en),
  .shift_dout (shift_dout),
  .unlocked   (unlocked),
  .len_cnt    (len_cnt),
  .set_unlock (set_unlock),
  .lk_state   (lk_state)
);

// File: tb/dbg_key_gate_test.sv
`timescale 1ns/1ps
module dbg_key_gate_test;

  localparam int KW = 64;
  localparam logic [KW-1:0] KEY_A = 64'hA5C3_1F00_7E29_D4B6;

  typedef struct {
    string tag;
    bit    unl;
    bit    use_dout;
    bit    dout;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sec_en = 1'b1;
  logic          shift_en = 1'b0;
  logic          shift_din = 1'b0;
  logic          update_en = 1'b0;
  logic [KW-1:0] dev_key = KEY_A;
  logic          shift_dout, unlocked, emu_allow, ext_boot_allow, boot_int_only;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_key_gate #(.KEY_W(KW)) uut (
    .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .shift_en(shift_en),
    .shift_din(shift_din), .update_en(update_en), .dev_key(dev_key),
    .shift_dout(shift_dout), .unlocked(unlocked), .emu_allow(emu_allow),
    .ext_boot_allow(ext_boot_allow), .boot_int_only(boot_int_only)
  );

  // Monitor: pops expectations and compares at negedge + 1 ns.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        logic [4:0] act, expv;
        e = q.pop_front();
        act  = {unlocked, emu_allow, ext_boot_allow, boot_int_only,
                e.use_dout ? shift_dout : 1'b0};
        expv = {e.unl, e.unl, e.unl, !e.unl, e.use_dout ? e.dout : 1'b0};
        n_chk++;
        if (act !== expv) begin
          n_fail++;
          $display("FAIL %s: {unl,emu,ext,int,dout} actual=%b expected=%b", e.tag, act, expv);
        end
      end
    end
  end

  task automatic expect_st(input string tag, input bit unl, input bit use_d, input bit d);
    exp_t e;
    @(negedge clk);
    shift_en = 1'b0; update_en = 1'b0;
    e.tag = tag; e.unl = unl; e.use_dout = use_d; e.dout = d;
    q.push_back(e);
  endtask

  task automatic do_reset(input bit strap);
    @(negedge clk);
    rst_n = 1'b0; sec_en = strap; shift_en = 1'b0; update_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drives n bits of v, least significant first, starting at bit 'from'.
  task automatic shift_bits(input logic [KW-1:0] v, input int n, input int from);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      shift_en = 1'b1; update_en = 1'b0; shift_din = v[from + i];
    end
  endtask

  task automatic pulse_update();
    @(negedge clk);
    shift_en = 1'b0; update_en = 1'b1;
  endtask

  function automatic logic [KW-1:0] bit_rev(input logic [KW-1:0] v);
    logic [KW-1:0] r;
    for (int i = 0; i < KW; i++) r[i] = v[KW-1-i];
    return r;
  endfunction

  initial begin
    do_reset(1'b1);
    expect_st("R1 reset closed", 1'b0, 1'b1, 1'b0);
    expect_st("R10 gates closed while sealed", 1'b0, 1'b0, 1'b0);

    shift_bits(KEY_A ^ 64'h0000_0100_0000_0000, KW, 0);
    pulse_update();
    expect_st("R5 one-bit-wrong key ignored", 1'b0, 1'b0, 1'b0);

    shift_bits(bit_rev(KEY_A), KW, 0);
    pulse_update();
    expect_st("R3 MSB-first order refused", 1'b0, 1'b1, 1'b0);

    shift_bits(KEY_A, KW - 1, 0);
    pulse_update();
    expect_st("R6 63-bit scan mismatch", 1'b0, 1'b0, 1'b0);

    @(negedge clk); shift_en = 1'b1; shift_din = 1'b1;
    shift_bits(KEY_A, KW, 0);
    pulse_update();
    expect_st("R6 65-bit scan mismatch", 1'b0, 1'b0, 1'b0);

    shift_bits(KEY_A, KW - 1, 0);
    @(negedge clk); shift_en = 1'b1; update_en = 1'b1; shift_din = KEY_A[KW-1];
    expect_st("R9 update beats coincident shift", 1'b0, 1'b1, 1'b0);

    shift_bits(KEY_A, KW, 0);
    expect_st("R3 dout shows first bit after 64 shifts", 1'b0, 1'b1, KEY_A[0]);
    pulse_update();
    expect_st("R4 correct key unlocks", 1'b1, 1'b0, 1'b0);
    expect_st("R8 register cleared after update", 1'b1, 1'b1, 1'b0);

    shift_bits(~KEY_A, KW, 0);
    pulse_update();
    expect_st("R7 wrong key after unlock keeps open", 1'b1, 1'b1, 1'b0);
    shift_bits(KEY_A, 5, 0);
    pulse_update();
    expect_st("R7 short key after unlock keeps open", 1'b1, 1'b0, 1'b0);

    do_reset(1'b1);
    expect_st("R1 reset relocks", 1'b0, 1'b1, 1'b0);
    dev_key = 64'h8000_0000_0000_0001;
    shift_bits(dev_key, KW, 0);
    pulse_update();
    expect_st("R4 second key unlocks", 1'b1, 1'b1, 1'b0);

    do_reset(1'b0);
    expect_st("R2 strap clear opens from reset", 1'b1, 1'b1, 1'b0);
    shift_bits(~dev_key, KW, 0);
    pulse_update();
    expect_st("R2 strap clear stays open", 1'b1, 1'b1, 1'b0);

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule